// File: doc/BRIEF.md
# Pattern-Synchronous Trigger Generator

This block drives a single trigger line for a serial bit stream that moves one bit per clock. It has two modes. In divided-clock mode the trigger is a square wave at the bit clock divided by a ratio picked from a small fixed set. This set includes 40, which is not a power of two. In pattern mode the block watches a one-cycle strobe that a pattern source raises at the start of each pattern repetition. It raises one pulse for every fourth repetition. The pulse starts with that repetition and lasts half the pattern length in clocks.

A change of mode or ratio is held back until the current divided period or the current pulse has ended. This keeps short or clipped pulses off the trigger line. Strobes are counted in both modes, so the one-in-four phase stays locked to the pattern stream across mode changes. Only a synchronous reset clears that count.

Top module: `pattern_trigger`

## Requirements
- R1: A synchronous reset (`rst` high at a rising edge) clears the repetition count to zero and ends any pulse. The output is low while reset is applied in pattern mode. After reset the first pattern-mode pulse follows the fourth strobe.
- R2: `ratio_code` selects the division ratio as follows: 0 gives 4, 1 gives 8, 2 gives 16, 3 gives 32, 4 gives 40, 5 gives 64 and 6 gives 128. Code 7 gives 4.
- R3: In divided-clock mode (`mode_sel` = 0) the output is a square wave of period N clocks. It is high for N/2 clocks and then low for N/2 clocks. The high half starts in the first cycle after reset and again after each period boundary.
- R4: In pattern mode (`mode_sel` = 1) exactly one pulse is produced for every fourth `pat_start` strobe. No pulse is produced for the other three.
- R5: A pattern-mode pulse goes high in the cycle after the clock edge that samples the firing strobe. It stays high for floor(`pat_len`/2) clocks. The width is at least one clock, which covers `pat_len` of 0 or 1.
- R6: A new `ratio_code` value takes effect only at the start of the next divided period. The period that is running completes at the old ratio.
- R7: A change of `mode_sel` is applied only at the end of a divided period or while no pulse is active. A pulse in progress finishes at full width. When divided mode is entered, it starts with a fresh high half.
- R8: `pat_start` strobes that arrive in divided-clock mode produce no pulse and leave the square wave unchanged. They still advance the repetition count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst | input | 1 | Synchronous reset, active high |
| mode_sel | input | 1 | 0 selects divided-clock mode, 1 selects pattern mode |
| ratio_code | input | 3 | Division ratio select (see R2) |
| pat_start | input | 1 | One-cycle strobe at the start of each pattern repetition |
| pat_len | input | LEN_W (24) | Pattern length in bits |
| trig_out | output | 1 | Trigger output |

## Verification
The trigger is decoded directly from registered state. Any input sampled at a rising edge therefore appears on `trig_out` one clock later. A strobe driven in cycle k first raises the pulse in cycle k+1. The divided wave is high in cycle 0 after reset and after each boundary. The bench changes inputs on the falling edge and compares `trig_out` on each falling edge before it drives the next input. Expected values come from a per-cycle index counted from reset release. For a deferred mode or ratio change, the expected switch cycle is worked out from the end of the running period or pulse, not from the cycle in which the input changed.

// File: rtl/pattern_trigger.sv
module pattern_trigger #(
  parameter int LEN_W = 24
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             mode_sel,
  input  logic [2:0]       ratio_code,
  input  logic             pat_start,
  input  logic [LEN_W-1:0] pat_len,
  output logic             trig_out
);

  localparam int CNT_W = 8;
  localparam int REPS  = 4;
  localparam int REP_W = $clog2(REPS);
  localparam logic [REP_W-1:0] LAST_REP = REP_W'(REPS - 1);

  function automatic logic [CNT_W-1:0] ratio_of(input logic [2:0] code);
    case (code)
      3'd1:    ratio_of = CNT_W'(8);
      3'd2:    ratio_of = CNT_W'(16);
      3'd3:    ratio_of = CNT_W'(32);
      3'd4:    ratio_of = CNT_W'(40);
      3'd5:    ratio_of = CNT_W'(64);
      3'd6:    ratio_of = CNT_W'(128);
      default: ratio_of = CNT_W'(4);
    endcase
  endfunction

  logic             act_mode;
  logic [CNT_W-1:0] act_ratio;
  logic [CNT_W-1:0] div_cnt;
  logic [REP_W-1:0] rep_cnt;
  logic [LEN_W-1:0] pulse_rem;

  logic [CNT_W-1:0] new_ratio;
  logic             div_end, pat_idle, switch_ok, fire;
  logic [LEN_W-1:0] half_len, width;

  assign new_ratio = ratio_of(ratio_code);
  assign div_end   = !act_mode && (div_cnt == act_ratio - CNT_W'(1));
  assign pat_idle  = act_mode && (pulse_rem == '0);
  assign switch_ok = div_end || pat_idle;
  assign fire      = act_mode && pat_start && (rep_cnt == LAST_REP)
                     && !(pat_idle && !mode_sel);
  assign half_len  = pat_len >> 1;
  assign width     = (half_len == '0) ? LEN_W'(1) : half_len;

  always_ff @(posedge clk) begin
    if (rst) begin
      act_mode  <= mode_sel;
      act_ratio <= new_ratio;
      div_cnt   <= '0;
      rep_cnt   <= '0;
      pulse_rem <= '0;
    end else begin
      if (pat_start) rep_cnt <= rep_cnt + REP_W'(1);
      if (switch_ok) begin
        act_mode  <= mode_sel;
        act_ratio <= new_ratio;
      end
      if (act_mode || div_end) div_cnt <= '0;
      else                     div_cnt <= div_cnt + CNT_W'(1);
      if (fire)                   pulse_rem <= width;
      else if (pulse_rem != '0)   pulse_rem <= pulse_rem - LEN_W'(1);
    end
  end

  assign trig_out = act_mode ? (pulse_rem != '0) : (div_cnt < (act_ratio >> 1));

  logic armed;
  always_ff @(posedge clk) armed <= !rst;

  // R2
  ratio_legal_chk: assert property (@(posedge clk) disable iff (rst || !armed)
    act_ratio inside {8'd4, 8'd8, 8'd16, 8'd32, 8'd40, 8'd64, 8'd128});

  // R3
  div_rise_chk: assert property (@(posedge clk) disable iff (rst || !armed)
    (!act_mode && $rose(trig_out)) |-> (div_cnt == '0));

  // R5
  pulse_origin_chk: assert property (@(posedge clk) disable iff (rst || !armed)
    (act_mode && $past(act_mode) && $rose(trig_out))
      |-> ($past(pat_start) && $past(rep_cnt) == LAST_REP));

  // R6
  ratio_hold_chk: assert property (@(posedge clk) disable iff (rst || !armed)
    (!act_mode && $past(!act_mode) && div_cnt != '0) |-> $stable(act_ratio));

  // R7
  mode_switch_chk: assert property (@(posedge clk) disable iff (rst || !armed)
    (act_mode != $past(act_mode)) |-> !$past(trig_out));

endmodule

// File: tb/pattern_trigger_test.sv
module pattern_trigger_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        mode_sel = 1'b0;
  logic [2:0]  ratio_code = 3'd0;
  logic        pat_start = 1'b0;
  logic [23:0] pat_len = 24'd8;
  logic        trig;

  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  pattern_trigger #(.LEN_W(24)) uut (
    .clk(clk), .rst(rst), .mode_sel(mode_sel), .ratio_code(ratio_code),
    .pat_start(pat_start), .pat_len(pat_len), .trig_out(trig)
  );

  task automatic chk(input logic got, input logic exp, input string req, input int i);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s cycle %0d: trig_out=%b expected %b", req, i, got, exp);
    end
  endtask

  task automatic do_reset(input logic m, input logic [2:0] rc, input logic [23:0] len);
    @(negedge clk);
    rst = 1'b1; mode_sel = m; ratio_code = rc; pat_len = len; pat_start = 1'b0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  function automatic int ratio_exp(input int code);
    case (code)
      1: return 8;   2: return 16;  3: return 32;
      4: return 40;  5: return 64;  6: return 128;
      default: return 4;
    endcase
  endfunction

  // R1: output low in reset, repetition count cleared
  task automatic t_reset();
    do_reset(1'b1, 3'd0, 24'd4);
    for (int i = 0; i < 4; i++) begin
      pat_start = (i % 2 == 0);
      @(negedge clk);
    end
    pat_start = 1'b0;
    rst = 1'b1;
    @(negedge clk);
    chk(trig, 1'b0, "R1 in reset", 0);
    @(negedge clk);
    rst = 1'b0;
    for (int i = 0; i < 17; i++) begin
      chk(trig, (i >= 13 && i <= 14), "R1 first pulse on fourth strobe", i);
      pat_start = (i % 4 == 0) && (i <= 12);
      @(negedge clk);
    end
    pat_start = 1'b0;
  endtask

  // R2, R3
  task automatic t_divided(input int code);
    int r;
    r = ratio_exp(code);
    do_reset(1'b0, 3'(code), 24'd8);
    for (int i = 0; i < 2 * r; i++) begin
      chk(trig, (i % r) < (r / 2), (code == 7) ? "R2 code 7" : "R2/R3 square wave", i);
      @(negedge clk);
    end
  endtask

  // R6
  task automatic t_ratio_change();
    do_reset(1'b0, 3'd1, 24'd8);
    for (int i = 0; i < 48; i++) begin
      chk(trig, (i < 8) ? (i < 4) : ((i - 8) < 20), "R6 ratio change deferred", i);
      if (i == 2) ratio_code = 3'd4;
      @(negedge clk);
    end
  endtask

  // R4, R5
  task automatic t_pattern(input int len, input int gap, input int nstr);
    int w, total;
    logic e;
    w = (len / 2 == 0) ? 1 : len / 2;
    total = gap * nstr + w + 3;
    do_reset(1'b1, 3'd0, 24'(len));
    for (int i = 0; i < total; i++) begin
      e = 1'b0;
      for (int m = 0; m < nstr; m++)
        if (((m + 1) % 4 == 0) && i >= gap * m + 1 && i <= gap * m + w) e = 1'b1;
      chk(trig, e, "R4/R5 pattern pulse", i);
      pat_start = (i % gap == 0) && (i / gap < nstr);
      @(negedge clk);
    end
    pat_start = 1'b0;
  endtask

  // R7: pattern to divided waits for pulse end
  task automatic t_pat_to_div();
    logic e;
    do_reset(1'b1, 3'd0, 24'd20);
    for (int i = 0; i < 84; i++) begin
      if (i >= 72)      e = ((i - 72) % 4) < 2;
      else              e = (i >= 61 && i <= 70);
      chk(trig, e, "R7 pattern to divided", i);
      pat_start = (i % 20 == 0) && (i <= 60);
      if (i == 63) mode_sel = 1'b0;
      @(negedge clk);
    end
    pat_start = 1'b0;
  endtask

  // R8, R7: strobes counted in divided mode, switch at period end
  task automatic t_div_to_pat();
    logic e;
    do_reset(1'b0, 3'd6, 24'd2);
    for (int i = 0; i < 136; i++) begin
      e = (i < 128) ? (i < 64) : (i == 131);
      chk(trig, e, (i < 128) ? "R8 strobes in divided mode" : "R7/R8 divided to pattern", i);
      pat_start = (i == 2 || i == 4 || i == 6 || i == 130);
      if (i == 10) mode_sel = 1'b1;
      @(negedge clk);
    end
    pat_start = 1'b0;
  endtask

  initial begin
    t_reset();
    for (int c = 0; c < 8; c++) t_divided(c);
    t_ratio_change();
    t_pattern(10, 10, 8);
    t_pattern(7, 7, 8);
    t_pattern(1, 4, 4);
    t_pattern(0, 3, 4);
    t_pat_to_div();
    t_div_to_pat();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL all requirements: watchdog expired, got running expected finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule